// File: doc/BRIEF.md
# CompactFlash Host Cycle Controller

This block is the host side of a CompactFlash socket. It takes single read or write requests from an internal bus and turns each one into a timed card cycle. A request carries an address, write data, byte enables, a direction and a space. The space is common memory, attribute memory or I/O. The block drives the card's 11-bit address, its 16-bit data bus, the two card enables, the register-select line and one of four active-low strobes. It then returns the read data, or an error flag, through a one-cycle done pulse.

Each cycle has three phases: setup, strobe-active and hold. Their lengths come from programmable counts of system clocks. The card's wait line is synchronised, and it can stretch the strobe once the minimum active count has elapsed. The block also watches the socket:
- Two card-detect inputs show whether a card is present.
- A voltage-sense input drives the 3.3 V power enable.
- A shared status pin is reported as ready/busy for a memory card or as an interrupt for an I/O card.
- An internal request drives the card reset line.

Requests that cannot run complete at once with an error and touch no strobe.

Top module: `cf_host_ctrl`

## Requirements
- R1: Lane encoding. With enables 2'b11, a word access drives both card enables low (`cf_ce_n`=2'b00) and forces card address bit 0 to 0. With enables 2'b01 (even byte) or 2'b10 (odd byte), a byte access drives `cf_ce_n`=2'b10 and sets address bit 0 to 0 or 1 respectively. The written byte is placed on data bits 7:0.
- R2: Space encoding. Space 2'b00 (common) drives `cf_reg_n` high, and space 2'b01 (attribute) drives it low. Space 2'b10 (I/O) also drives it low. Space 2'b11 is rejected with an error.
- R3: A memory or attribute read pulses `cf_oe_n`, and a memory or attribute write pulses `cf_we_n`. An I/O read pulses `cf_iord_n`, and an I/O write pulses `cf_iowr_n`. At most one strobe is low at any time, and only while a card enable is low.
- R4: With setup count S, active count A and hold count H, and no wait, the phases last fixed numbers of cycles. Address and enables are valid with the strobe high for S+1 cycles. The strobe is then low for A+1 cycles. Address, enables and write data stay for H+1 further cycles. `rsp_done` rises on the next edge, so a write's data is still driven when `cf_we_n` rises.
- R5: The wait input is only looked at once the active count has run out. The strobe stays low while the synchronised `cf_wait_n` is 0. It rises on the third clock edge after `cf_wait_n` returns to 1, unless the active count ends later.
- R6: `card_present` is 1 only when both bits of `cf_cd_n` are 0, two edges after they settle. A request made with no card present completes on the next edge with `rsp_done` and `rsp_err` both 1 and no strobe or enable activity.
- R7: `cf_reset` follows `reset_card` one edge later. A request made while `cf_reset` is 1 completes with an error, as in R6.
- R8: `cf_pwr_en_n` equals `cf_vs_n` delayed by three clock edges: low only when sense reads 0, high otherwise.
- R9: When `io_mode` is 0, `card_ready` shows `cf_rdy_irq` (1 = ready) and `card_irq` is 0. When `io_mode` is 1, `card_irq` is the inverse of `cf_rdy_irq` and `card_ready` is 0. Both outputs see the pin two edges late.
- R10: A request with byte enables 2'b00 completes with an error, as in R6.
- R11: A read returns `cf_data_in` as sampled on the last strobe-active cycle. A word read returns all 16 bits. An even-byte read returns data bits 7:0 in `rsp_rdata[7:0]` and an odd-byte read returns them in `rsp_rdata[15:8]`; the other byte is 0 in both cases.
- R12: After reset, all strobes and card enables are high, `cf_reset` is 0, `cf_pwr_en_n` is 1, `rsp_done` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken while `req_ready` is 1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_space | input | 2 | 00 common, 01 attribute, 10 I/O, 11 invalid |
| req_addr | input | 11 | Card address |
| req_be | input | 2 | Byte enables (bit 0 even, bit 1 odd) |
| req_wdata | input | 16 | Write data |
| t_setup | input | 4 | Setup count S |
| t_active | input | 4 | Minimum strobe count A |
| t_hold | input | 4 | Hold count H |
| io_mode | input | 1 | Status pin is an interrupt (1) or ready/busy (0) |
| reset_card | input | 1 | Request to hold the card in reset |
| req_ready | output | 1 | Controller idle |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Completion was rejected |
| rsp_rdata | output | 16 | Read data |
| card_present | output | 1 | Both detects low |
| card_ready | output | 1 | Memory card ready |
| card_irq | output | 1 | I/O card interrupt request |
| cf_addr | output | 11 | Card address |
| cf_data_out | output | 16 | Card write data |
| cf_data_oe | output | 1 | Card data drive enable |
| cf_data_in | input | 16 | Card read data |
| cf_ce_n | output | 2 | Card enables (bit 0 even, bit 1 odd) |
| cf_reg_n | output | 1 | Register select, low for attribute and I/O |
| cf_oe_n | output | 1 | Memory read strobe |
| cf_we_n | output | 1 | Memory write strobe |
| cf_iord_n | output | 1 | I/O read strobe |
| cf_iowr_n | output | 1 | I/O write strobe |
| cf_wait_n | input | 1 | Card wait request, active low |
| cf_cd_n | input | 2 | Card detects, active low |
| cf_vs_n | input | 1 | Voltage sense |
| cf_rdy_irq | input | 1 | Ready/busy or interrupt status pin |
| cf_pwr_en_n | output | 1 | 3.3 V power enable, active low |
| cf_reset | output | 1 | Card reset, active high |

## Verification
A phase counter that loads or counts down wrongly shows up in the very cycle it acts. The setup, strobe-low and hold widths seen at the pins then differ from S+1, A+1 and H+1, and `rsp_done` arrives on the wrong edge. A wrong wait path shows within three edges of the wait release, as a strobe that ends too early or too late. A wrong lane or space decode shows in the enables, address bit 0, `cf_reg_n` or the chosen strobe during the first setup cycle. Wrong read steering shows in `rsp_rdata` with the done pulse.

// File: rtl/cf_host_pkg.sv
package cf_host_pkg;
  typedef enum logic [1:0] {
    SP_COMMON = 2'b00,
    SP_ATTR   = 2'b01,
    SP_IO     = 2'b10,
    SP_BAD    = 2'b11
  } cf_space_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_ACTIVE,
    PH_HOLD
  } cf_phase_e;
endpackage

// File: rtl/cf_sync.sv
module cf_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= RST_VAL;
    else        stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= RST_VAL;
      else        stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cf_lane_map.sv
module cf_lane_map #(
  parameter int AW = 11,
  parameter int DW = 16
) (
  input  logic [AW-1:0] addr,
  input  logic [1:0]    be,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] card_din,
  output logic [AW-1:0] pin_addr,
  output logic [1:0]    pin_ce_n,
  output logic [DW-1:0] pin_wdata,
  output logic [DW-1:0] host_rdata
);
  localparam int HB = DW / 2;

  logic word, odd;
  assign word = (be == 2'b11);
  assign odd  = (be == 2'b10);

  always_comb begin
    pin_addr    = addr;
    pin_addr[0] = word ? 1'b0 : odd;
    pin_ce_n    = word ? 2'b00 : 2'b10;
    if (word) begin
      pin_wdata  = wdata;
      host_rdata = card_din;
    end else begin
      pin_wdata  = '0;
      host_rdata = '0;
      pin_wdata[HB-1:0] = odd ? wdata[DW-1:HB] : wdata[HB-1:0];
      if (odd) host_rdata[DW-1:HB] = card_din[HB-1:0];
      else     host_rdata[HB-1:0]  = card_din[HB-1:0];
    end
  end
endmodule

// File: rtl/cf_cycle_seq.sv
module cf_cycle_seq
  import cf_host_pkg::*;
#(
  parameter int AW = 11,
  parameter int DW = 16,
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [1:0]    req_space,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_be,
  input  logic [DW-1:0] req_wdata,
  input  logic          reject,
  input  logic [TW-1:0] t_setup,
  input  logic [TW-1:0] t_active,
  input  logic [TW-1:0] t_hold,
  input  logic          wait_ok,
  input  logic [DW-1:0] rd_mapped,
  output cf_phase_e     phase,
  output logic          lat_write,
  output logic [1:0]    lat_space,
  output logic [AW-1:0] lat_addr,
  output logic [1:0]    lat_be,
  output logic [DW-1:0] lat_wdata,
  output logic          oe_n,
  output logic          we_n,
  output logic          iord_n,
  output logic          iowr_n,
  output logic          done,
  output logic          err,
  output logic [DW-1:0] rdata
);
  cf_phase_e     ph_nxt;
  logic [TW-1:0] cnt, cnt_nxt;
  logic          take, cap, done_nxt, err_nxt;
  logic          act_nxt, io_l;

  always_comb begin
    ph_nxt   = phase;
    cnt_nxt  = cnt;
    take     = 1'b0;
    cap      = 1'b0;
    done_nxt = 1'b0;
    err_nxt  = 1'b0;
    unique case (phase)
      PH_IDLE: if (req_valid) begin
        if (reject) begin
          done_nxt = 1'b1;
          err_nxt  = 1'b1;
        end else begin
          take    = 1'b1;
          ph_nxt  = PH_SETUP;
          cnt_nxt = t_setup;
        end
      end
      PH_SETUP: if (cnt == '0) begin
        ph_nxt  = PH_ACTIVE;
        cnt_nxt = t_active;
      end else cnt_nxt = cnt - 1'b1;
      PH_ACTIVE: if (cnt != '0) cnt_nxt = cnt - 1'b1;
      else if (wait_ok) begin
        ph_nxt  = PH_HOLD;
        cnt_nxt = t_hold;
        cap     = 1'b1;
      end
      PH_HOLD: if (cnt == '0) begin
        ph_nxt   = PH_IDLE;
        done_nxt = 1'b1;
      end else cnt_nxt = cnt - 1'b1;
      default: ph_nxt = PH_IDLE;
    endcase
  end

  assign act_nxt = (ph_nxt == PH_ACTIVE);
  assign io_l    = (lat_space == SP_IO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      done   <= 1'b0;
      err    <= 1'b0;
      oe_n   <= 1'b1;
      we_n   <= 1'b1;
      iord_n <= 1'b1;
      iowr_n <= 1'b1;
    end else begin
      phase  <= ph_nxt;
      cnt    <= cnt_nxt;
      done   <= done_nxt;
      err    <= err_nxt;
      oe_n   <= ~(act_nxt & ~io_l & ~lat_write);
      we_n   <= ~(act_nxt & ~io_l &  lat_write);
      iord_n <= ~(act_nxt &  io_l & ~lat_write);
      iowr_n <= ~(act_nxt &  io_l &  lat_write);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_write <= 1'b0;
      lat_space <= SP_COMMON;
      lat_addr  <= '0;
      lat_be    <= 2'b11;
      lat_wdata <= '0;
    end else if (take) begin
      lat_write <= req_write;
      lat_space <= req_space;
      lat_addr  <= req_addr;
      lat_be    <= req_be;
      lat_wdata <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   rdata <= '0;
    else if (cap) rdata <= lat_write ? '0 : rd_mapped;
  end
endmodule

// File: rtl/cf_host_ctrl.sv
module cf_host_ctrl
  import cf_host_pkg::*;
#(
  parameter int AW    = 11,
  parameter int DW    = 16,
  parameter int TW    = 4,
  parameter int SYNCS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [1:0]    req_space,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_be,
  input  logic [DW-1:0] req_wdata,
  input  logic [TW-1:0] t_setup,
  input  logic [TW-1:0] t_active,
  input  logic [TW-1:0] t_hold,
  input  logic          io_mode,
  input  logic          reset_card,
  output logic          req_ready,
  output logic          rsp_done,
  output logic          rsp_err,
  output logic [DW-1:0] rsp_rdata,
  output logic          card_present,
  output logic          card_ready,
  output logic          card_irq,
  output logic [AW-1:0] cf_addr,
  output logic [DW-1:0] cf_data_out,
  output logic          cf_data_oe,
  input  logic [DW-1:0] cf_data_in,
  output logic [1:0]    cf_ce_n,
  output logic          cf_reg_n,
  output logic          cf_oe_n,
  output logic          cf_we_n,
  output logic          cf_iord_n,
  output logic          cf_iowr_n,
  input  logic          cf_wait_n,
  input  logic [1:0]    cf_cd_n,
  input  logic          cf_vs_n,
  input  logic          cf_rdy_irq,
  output logic          cf_pwr_en_n,
  output logic          cf_reset
);
  logic          wait_ok, vs_s, rdy_s;
  logic [1:0]    cd_s;
  logic          reject, busy;
  cf_phase_e     phase;
  logic          lat_write;
  logic [1:0]    lat_space, lat_be;
  logic [AW-1:0] lat_addr, map_addr;
  logic [DW-1:0] lat_wdata, map_wdata, rd_mapped;
  logic [1:0]    map_ce_n;

  cf_sync #(.W(1), .STAGES(SYNCS), .RST_VAL(1'b1)) u_sync_wait (
    .clk(clk), .rst_n(rst_n), .d(cf_wait_n), .q(wait_ok));
  cf_sync #(.W(2), .STAGES(SYNCS), .RST_VAL(2'b11)) u_sync_cd (
    .clk(clk), .rst_n(rst_n), .d(cf_cd_n), .q(cd_s));
  cf_sync #(.W(1), .STAGES(SYNCS), .RST_VAL(1'b1)) u_sync_vs (
    .clk(clk), .rst_n(rst_n), .d(cf_vs_n), .q(vs_s));
  cf_sync #(.W(1), .STAGES(SYNCS), .RST_VAL(1'b0)) u_sync_rdy (
    .clk(clk), .rst_n(rst_n), .d(cf_rdy_irq), .q(rdy_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cf_pwr_en_n <= 1'b1;
      cf_reset    <= 1'b0;
    end else begin
      cf_pwr_en_n <= vs_s;
      cf_reset    <= reset_card;
    end
  end

  assign card_present = ~|cd_s;
  assign card_ready   = ~io_mode & rdy_s;
  assign card_irq     =  io_mode & ~rdy_s;

  assign reject = ~card_present | cf_reset | (req_be == 2'b00) |
                  (req_space == SP_BAD);

  cf_cycle_seq #(.AW(AW), .DW(DW), .TW(TW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_space(req_space),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .reject(reject), .t_setup(t_setup), .t_active(t_active), .t_hold(t_hold),
    .wait_ok(wait_ok), .rd_mapped(rd_mapped),
    .phase(phase), .lat_write(lat_write), .lat_space(lat_space),
    .lat_addr(lat_addr), .lat_be(lat_be), .lat_wdata(lat_wdata),
    .oe_n(cf_oe_n), .we_n(cf_we_n), .iord_n(cf_iord_n), .iowr_n(cf_iowr_n),
    .done(rsp_done), .err(rsp_err), .rdata(rsp_rdata));

  cf_lane_map #(.AW(AW), .DW(DW)) u_lane (
    .addr(lat_addr), .be(lat_be), .wdata(lat_wdata), .card_din(cf_data_in),
    .pin_addr(map_addr), .pin_ce_n(map_ce_n), .pin_wdata(map_wdata),
    .host_rdata(rd_mapped));

  assign busy        = (phase != PH_IDLE);
  assign req_ready   = ~busy;
  assign cf_addr     = busy ? map_addr : '0;
  assign cf_ce_n     = busy ? map_ce_n : 2'b11;
  assign cf_reg_n    = busy ? (lat_space == SP_COMMON) : 1'b1;
  assign cf_data_oe  = busy & lat_write;
  assign cf_data_out = cf_data_oe ? map_wdata : '0;
endmodule

// File: rtl/cf_host_ctrl_chk.sv
module cf_host_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       oe_n,
  input logic       we_n,
  input logic       iord_n,
  input logic       iowr_n,
  input logic [1:0] ce_n,
  input logic       reg_n,
  input logic       data_oe,
  input logic       wait_ok,
  input logic       done,
  input logic       err
);
  logic any_low, all_high;
  assign any_low  = !oe_n || !we_n || !iord_n || !iowr_n;
  assign all_high = oe_n && we_n && iord_n && iowr_n;

  assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~oe_n, ~we_n, ~iord_n, ~iowr_n}) <= 1);

  assert_strobe_with_enable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    any_low |-> (ce_n != 2'b11));

  assert_io_reg_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!iord_n || !iowr_n) |-> !reg_n);

  assert_data_at_we_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> data_oe);

  assert_wait_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(all_high) |-> $past(wait_ok));

  assert_err_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
endmodule

bind cf_host_ctrl cf_host_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .oe_n(cf_oe_n), .we_n(cf_we_n),
  .iord_n(cf_iord_n), .iowr_n(cf_iowr_n), .ce_n(cf_ce_n), .reg_n(cf_reg_n),
  .data_oe(cf_data_oe), .wait_ok(wait_ok), .done(rsp_done), .err(rsp_err));

// File: tb/cf_host_ctrl_tb.sv
module cf_host_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, io_mode, reset_card;
  logic [1:0]  req_space, req_be;
  logic [10:0] req_addr;
  logic [15:0] req_wdata;
  logic [3:0]  t_setup, t_active, t_hold;
  logic        req_ready, rsp_done, rsp_err, card_present, card_ready, card_irq;
  logic [15:0] rsp_rdata, cf_data_out, cf_data_in;
  logic [10:0] cf_addr;
  logic        cf_data_oe, cf_reg_n, cf_oe_n, cf_we_n, cf_iord_n, cf_iowr_n;
  logic [1:0]  cf_ce_n, cf_cd_n;
  logic        cf_wait_n, cf_vs_n, cf_rdy_irq, cf_pwr_en_n, cf_reset;
  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  cf_host_ctrl u_dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // rel: active sample at which wait is released (0 = wait never asserted)
  task automatic run_cycle(input logic [1:0] sp, input logic wr, input logic [10:0] ad,
                           input logic [1:0] be, input logic [15:0] wd,
                           input logic [15:0] din, input int s, input int a,
                           input int h, input int rel, input bit exp_err);
    int n_pre = 0, n_act = 0, n_post = 0, edges = 0, pin_bad = 0, strb_bad = 0;
    int exp_act;
    logic [1:0]  e_ce;
    logic [10:0] e_ad;
    logic [15:0] e_wd, e_rd;
    logic        e_strb_ok;
    e_ce = (be == 2'b11) ? 2'b00 : 2'b10;
    e_ad = {ad[10:1], (be == 2'b10)};
    e_wd = (be == 2'b11) ? wd : {8'h00, be[1] ? wd[15:8] : wd[7:0]};
    e_rd = (be == 2'b11) ? din : (be[1] ? {din[7:0], 8'h00} : {8'h00, din[7:0]});
    exp_act = (rel > 0 && rel + 2 > a + 1) ? rel + 2 : a + 1;
    @(negedge clk);
    t_setup = 4'(s); t_active = 4'(a); t_hold = 4'(h);
    req_space = sp; req_write = wr; req_addr = ad; req_be = be; req_wdata = wd;
    cf_data_in = din; req_valid = 1'b1;
    if (rel > 0) cf_wait_n = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    edges = 1;
    while (!rsp_done && edges < 200) begin
      if (cf_ce_n != 2'b11) begin
        if (cf_ce_n !== e_ce || cf_addr !== e_ad || cf_reg_n !== (sp == 2'b00) ||
            cf_data_oe !== wr || (wr && cf_data_out !== e_wd)) pin_bad++;
      end
      if (!cf_oe_n || !cf_we_n || !cf_iord_n || !cf_iowr_n) begin
        n_act++;
        e_strb_ok = (sp == 2'b10) ? (wr ? !cf_iowr_n : !cf_iord_n)
                                  : (wr ? !cf_we_n : !cf_oe_n);
        if (!e_strb_ok) strb_bad++;
        if (rel > 0 && n_act == rel) cf_wait_n = 1'b1;
      end else if (cf_ce_n != 2'b11) begin
        if (n_act == 0) n_pre++;
        else n_post++;
      end
      @(negedge clk);
      edges++;
    end
    cf_wait_n = 1'b1;
    if (exp_err) begin
      chk(rsp_done && rsp_err && edges == 1 && n_pre + n_act + n_post == 0,
          "R6/R7/R10 reject response", {edges[15:0], 14'd0, rsp_done, rsp_err}, 32'h0001_0003);
    end else begin
      chk(!rsp_err, "R4 no error on good cycle", rsp_err, 0);
      chk(pin_bad == 0, "R1/R2 address, enables, reg select, data", pin_bad, 0);
      chk(strb_bad == 0, "R3 strobe selection", strb_bad, 0);
      chk(n_pre == s + 1 && n_post == h + 1, "R4 setup and hold widths",
          {n_pre[15:0], n_post[15:0]}, {16'(s + 1), 16'(h + 1)});
      chk(n_act == exp_act, rel > 0 ? "R5 strobe width with wait" : "R4 strobe width",
          n_act, exp_act);
      chk(edges == s + exp_act + h + 3, "R4 done timing", edges, s + exp_act + h + 3);
      if (!wr) chk(rsp_rdata == e_rd, "R11 read data steering", rsp_rdata, e_rd);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_space = 2'b00;
    req_addr = '0; req_be = 2'b11; req_wdata = '0; t_setup = '0; t_active = '0;
    t_hold = '0; io_mode = 1'b0; reset_card = 1'b0; cf_data_in = '0;
    cf_wait_n = 1'b1; cf_cd_n = 2'b00; cf_vs_n = 1'b1; cf_rdy_irq = 1'b0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk({cf_oe_n, cf_we_n, cf_iord_n, cf_iowr_n, cf_ce_n} == 6'h3F &&
        !cf_reset && cf_pwr_en_n && !rsp_done && req_ready, "R12 reset state",
        {cf_oe_n, cf_we_n, cf_iord_n, cf_iowr_n, cf_ce_n, cf_reset, cf_pwr_en_n,
         rsp_done, req_ready}, 10'b1111110101);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(card_present, "R6 card present with both detects low", card_present, 1);

    // timing, space, direction and lane sweep
    for (int s = 0; s < 3; s++)
      for (int a = 0; a < 3; a++)
        for (int h = 0; h < 3; h++)
          for (int sp = 0; sp < 3; sp++)
            for (int wr = 0; wr < 2; wr++) begin
              logic [1:0] be;
              be = 2'((s + a + h + sp + wr) % 3 + 1);
              run_cycle(2'(sp), wr[0], 11'(37 * (s + 3 * a + 9 * h) + sp),
                        be, 16'(16'h1357 * (sp + 1) + 16'(wr * 16'h0F0F)),
                        16'(16'hA5C3 ^ 16'(a * 16'h1111 + h)), s, a, h, 0, 1'b0);
            end

    // R5 wait stretching
    run_cycle(2'b00, 1'b0, 11'h123, 2'b11, 16'h0, 16'hBEEF, 0, 0, 1, 1, 1'b0);
    run_cycle(2'b10, 1'b1, 11'h055, 2'b01, 16'h77AA, 16'h0, 1, 0, 0, 4, 1'b0);
    run_cycle(2'b01, 1'b0, 11'h2F1, 2'b10, 16'h0, 16'h4C21, 0, 6, 1, 1, 1'b0);
    run_cycle(2'b10, 1'b0, 11'h700, 2'b11, 16'h0, 16'h9001, 2, 2, 0, 2, 1'b0);

    // R10 and R2 rejects
    run_cycle(2'b00, 1'b1, 11'h010, 2'b00, 16'h1234, 16'h0, 1, 1, 1, 0, 1'b1);
    run_cycle(2'b11, 1'b0, 11'h010, 2'b11, 16'h0, 16'h0, 1, 1, 1, 0, 1'b1);

    // R6 card absence
    cf_cd_n = 2'b11;
    repeat (3) @(negedge clk);
    chk(!card_present, "R6 no card", card_present, 0);
    run_cycle(2'b00, 1'b0, 11'h001, 2'b11, 16'h0, 16'h0, 0, 0, 0, 0, 1'b1);
    cf_cd_n = 2'b01;
    repeat (3) @(negedge clk);
    chk(!card_present, "R6 one detect only", card_present, 0);
    run_cycle(2'b10, 1'b1, 11'h001, 2'b11, 16'h5555, 16'h0, 0, 0, 0, 0, 1'b1);
    cf_cd_n = 2'b00;
    repeat (3) @(negedge clk);

    // R7 card reset
    reset_card = 1'b1;
    @(negedge clk);
    chk(cf_reset, "R7 reset follows request", cf_reset, 1);
    run_cycle(2'b00, 1'b1, 11'h002, 2'b11, 16'h1111, 16'h0, 0, 0, 0, 0, 1'b1);
    reset_card = 1'b0;
    @(negedge clk);
    chk(!cf_reset, "R7 reset released", cf_reset, 0);
    run_cycle(2'b00, 1'b0, 11'h004, 2'b01, 16'h0, 16'h00C7, 0, 0, 0, 0, 1'b0);

    // R8 power enable
    cf_vs_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(cf_pwr_en_n, "R8 power enable not yet low", cf_pwr_en_n, 1);
    @(negedge clk);
    chk(!cf_pwr_en_n, "R8 power enable low", cf_pwr_en_n, 0);
    cf_vs_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(cf_pwr_en_n, "R8 power enable high", cf_pwr_en_n, 1);

    // R9 status pin
    for (int m = 0; m < 2; m++)
      for (int r = 0; r < 2; r++) begin
        io_mode = m[0]; cf_rdy_irq = r[0];
        repeat (2) @(negedge clk);
        chk({card_ready, card_irq} == (m == 0 ? {r[0], 1'b0} : {1'b0, ~r[0]}),
            "R9 status interpretation", {card_ready, card_irq},
            (m == 0 ? {r[0], 1'b0} : {1'b0, ~r[0]}));
      end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule